// File: doc/BRIEF.md
# Two-Level Loop Context Stack

This block holds the saved context of up to two nested hardware DO loops in a program sequencer. A loop start places a 16-bit context word on the stack. A loop end takes it off again. Software can also save and restore the stack through a write strobe and a read strobe on the stack register. Each software access moves one entry, so a task switch can drain the stack and later rebuild it.

The block does not keep an occupancy counter. Occupancy lives only in two flags: the loop flag and the nested flag. A push moves the loop flag into the nested flag and then sets the loop flag. A pop moves the nested flag into the loop flag and then clears the nested flag. A loop start that finds both flags set does not push. It raises an overflow interrupt pulse instead.

The block also produces a 16-bit mode-register view. This view carries the nested flag at bit 15, forces the reserved bit positions to zero, and passes the remaining mode bits through from the sequencer.

Top module: `loop_ctx_stack`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `lf_o`, `nl_o`, `ovf_irq_o` and `underflow_o` are 0 and `tos_o` is zero.
- R2: The flag pair {nl_o, lf_o} reads 2'b00 with no loop active, 2'b01 with one loop active and 2'b11 with two loops active. The pair never reads 2'b10.
- R3: A loop start (`do_push_i`) with fewer than two loops active stores `do_ctx_i` as the new top entry. The old top becomes the inner-most saved entry. After the clock edge, `nl_o` equals the old `lf_o` and `lf_o` is 1.
- R4: A loop start with both flags set stores nothing and leaves the flags and `tos_o` unchanged. It drives `ovf_irq_o` high for exactly the one cycle after the edge.
- R5: A loop end (`loop_pop_i`) removes the top entry, and the entry beneath it becomes the top. After the edge, `lf_o` equals the old `nl_o` and `nl_o` is 0.
- R6: A software write (`sw_wr_i`) pushes `sw_wr_data_i` with the same flag update as R3, whatever the occupancy. When two loops are already active, the bottom entry is discarded and no overflow is raised.
- R7: During a software read (`sw_rd_i`), `tos_o` shows the current top value in that same cycle. At the edge, the read then pops exactly as in R5.
- R8: `tos_o` is zero whenever `lf_o` is 0. A pop of either kind with both flags clear leaves the flags at 0 and drives `underflow_o` high for the one cycle after the edge.
- R9: Only one request is served per cycle. The priority is software write first, then software read, then loop start, then loop end.
- R10: `mode_view_o[15]` equals `nl_o`. Bits 2, 7 and 9 to 14 of `mode_view_o` are 0. Every other bit equals the same bit of `mode_ctl_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| do_push_i | input | 1 | Loop start request |
| do_ctx_i | input | 16 | Context word stored by a loop start |
| loop_pop_i | input | 1 | Loop end request |
| sw_wr_i | input | 1 | Software write strobe to the stack register |
| sw_wr_data_i | input | 16 | Data for a software write |
| sw_rd_i | input | 1 | Software read strobe (also used for test-only reads) |
| mode_ctl_i | input | 16 | Remaining mode bits merged into the view |
| tos_o | output | 16 | Top entry, or zero when no loop is active |
| lf_o | output | 1 | Loop flag |
| nl_o | output | 1 | Nested-loop flag |
| mode_view_o | output | 16 | Mode-register read view |
| ovf_irq_o | output | 1 | Stack overflow interrupt pulse |
| underflow_o | output | 1 | Underflow pulse after a pop from an empty stack |

## Verification
The bench fills the stack through loop starts and drains it through loop ends. This separates the flag shift itself from the order in which entries come back out. A third loop start against a full stack is then contrasted with a software write against a full stack: only the loop start may raise overflow, and only the write discards the bottom entry. Reads and loop ends on an empty stack show that underflow leaves the flags at zero and gives a zero top. Requests that are asserted together show that priority picks exactly one action. A mode input of all ones and of all zeros, under both nested-flag states, separates the masking of the reserved bits from the placement of the nested flag.

// File: rtl/loop_ctx_pkg.sv
package loop_ctx_pkg;
   typedef enum logic [1:0] {
      LOP_NONE = 2'd0,
      LOP_PUSH = 2'd1,
      LOP_POP  = 2'd2
   } lop_e;

   localparam logic [15:0] LCS_RSVD_DEFAULT =
      (16'h1 << 2) | (16'h1 << 7) | (((16'h1 << 6) - 16'h1) << 9);
endpackage

// File: rtl/lcs_op_decode.sv
module lcs_op_decode
   import loop_ctx_pkg::*;
(
   input  logic sw_wr,
   input  logic sw_rd,
   input  logic do_push,
   input  logic loop_pop,
   input  logic lf,
   input  logic nl,
   output lop_e op,
   output logic sel_sw_data,
   output logic ovf_evt,
   output logic udf_evt
);
   logic full;
   assign full = lf & nl;

   always_comb begin
      op          = LOP_NONE;
      sel_sw_data = 1'b0;
      ovf_evt     = 1'b0;
      udf_evt     = 1'b0;
      if (sw_wr) begin
         op          = LOP_PUSH;
         sel_sw_data = 1'b1;
      end else if (sw_rd) begin
         op      = LOP_POP;
         udf_evt = ~lf;
      end else if (do_push) begin
         if (full) ovf_evt = 1'b1;
         else      op      = LOP_PUSH;
      end else if (loop_pop) begin
         op      = LOP_POP;
         udf_evt = ~lf;
      end
   end
endmodule

// File: rtl/lcs_flags.sv
module lcs_flags
   import loop_ctx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  lop_e op,
   input  logic ovf_evt,
   input  logic udf_evt,
   output logic lf,
   output logic nl,
   output logic ovf_q,
   output logic udf_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lf    <= 1'b0;
         nl    <= 1'b0;
         ovf_q <= 1'b0;
         udf_q <= 1'b0;
      end else begin
         ovf_q <= ovf_evt;
         udf_q <= udf_evt;
         case (op)
            LOP_PUSH: begin
               nl <= lf;
               lf <= 1'b1;
            end
            LOP_POP: begin
               lf <= nl;
               nl <= 1'b0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/lcs_entries.sv
module lcs_entries
   import loop_ctx_pkg::*;
#(
   parameter int W            = 16,
   parameter int DEPTH        = 2,
   parameter bit CLEAR_ON_POP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  lop_e         op,
   input  logic [W-1:0] din,
   output logic [W-1:0] top
);
   localparam int LAST = DEPTH - 1;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [W-1:0] q;
      logic [W-1:0] from_above;
      logic [W-1:0] from_below;

      if (i == 0) begin : g_first
         assign from_above = din;
      end else begin : g_inner
         assign from_above = g_ent[i-1].q;
      end

      if (i == LAST) begin : g_last
         if (CLEAR_ON_POP) begin : g_clr
            assign from_below = '0;
         end else begin : g_keep
            assign from_below = q;
         end
      end else begin : g_mid
         assign from_below = g_ent[i+1].q;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                q <= '0;
         else if (op == LOP_PUSH)   q <= from_above;
         else if (op == LOP_POP)    q <= from_below;
      end
   end

   assign top = g_ent[0].q;
endmodule

// File: rtl/lcs_mode_view.sv
module lcs_mode_view #(
   parameter int              MODE_W    = 16,
   parameter int              NL_BIT    = 15,
   parameter logic [MODE_W-1:0] RSVD_MASK = '0
) (
   input  logic [MODE_W-1:0] mode_in,
   input  logic              nl,
   output logic [MODE_W-1:0] view
);
   localparam logic [MODE_W-1:0] NL_MASK   = MODE_W'(1) << NL_BIT;
   localparam logic [MODE_W-1:0] PASS_MASK = ~(RSVD_MASK | NL_MASK);

   assign view = (mode_in & PASS_MASK) | (nl ? NL_MASK : '0);
endmodule

// File: rtl/loop_ctx_stack.sv
module loop_ctx_stack
   import loop_ctx_pkg::*;
#(
   parameter int          W            = 16,
   parameter int          DEPTH        = 2,
   parameter int          MODE_W       = 16,
   parameter int          NL_BIT       = 15,
   parameter logic [15:0] RSVD_MASK    = LCS_RSVD_DEFAULT,
   parameter bit          CLEAR_ON_POP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          do_push_i,
   input  logic [W-1:0]  do_ctx_i,
   input  logic          loop_pop_i,
   input  logic          sw_wr_i,
   input  logic [W-1:0]  sw_wr_data_i,
   input  logic          sw_rd_i,
   input  logic [15:0]   mode_ctl_i,
   output logic [W-1:0]  tos_o,
   output logic          lf_o,
   output logic          nl_o,
   output logic [15:0]   mode_view_o,
   output logic          ovf_irq_o,
   output logic          underflow_o
);
   if (DEPTH != 2) begin : g_bad_depth
      $error("loop_ctx_stack: flag pair encodes exactly two levels");
   end
   if (W < 1) begin : g_bad_width
      $error("loop_ctx_stack: entry width must be positive");
   end
   if (MODE_W != 16) begin : g_bad_mode_w
      $error("loop_ctx_stack: mode view is 16 bits");
   end
   if (NL_BIT < 0 || NL_BIT >= MODE_W) begin : g_bad_nl_bit
      $error("loop_ctx_stack: nested flag position outside view");
   end else if (RSVD_MASK[NL_BIT]) begin : g_nl_rsvd
      $error("loop_ctx_stack: nested flag position is reserved");
   end

   lop_e         op;
   logic         sel_sw;
   logic         ovf_evt;
   logic         udf_evt;
   logic         lf;
   logic         nl;
   logic [W-1:0] top;
   logic [W-1:0] din;

   lcs_op_decode u_dec (
      .sw_wr       (sw_wr_i),
      .sw_rd       (sw_rd_i),
      .do_push     (do_push_i),
      .loop_pop    (loop_pop_i),
      .lf          (lf),
      .nl          (nl),
      .op          (op),
      .sel_sw_data (sel_sw),
      .ovf_evt     (ovf_evt),
      .udf_evt     (udf_evt)
   );

   lcs_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .ovf_evt (ovf_evt),
      .udf_evt (udf_evt),
      .lf      (lf),
      .nl      (nl),
      .ovf_q   (ovf_irq_o),
      .udf_q   (underflow_o)
   );

   assign din = sel_sw ? sw_wr_data_i : do_ctx_i;

   lcs_entries #(
      .W            (W),
      .DEPTH        (DEPTH),
      .CLEAR_ON_POP (CLEAR_ON_POP)
   ) u_ent (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .din   (din),
      .top   (top)
   );

   lcs_mode_view #(
      .MODE_W    (16),
      .NL_BIT    (NL_BIT),
      .RSVD_MASK (RSVD_MASK)
   ) u_view (
      .mode_in (mode_ctl_i),
      .nl      (nl),
      .view    (mode_view_o)
   );

   assign tos_o = lf ? top : '0;
   assign lf_o  = lf;
   assign nl_o  = nl;
endmodule

// File: rtl/lcs_chk.sv
module lcs_chk #(
   parameter int          W         = 16,
   parameter int          NL_BIT    = 15,
   parameter logic [15:0] RSVD_MASK = 16'h7E84
) (
   input logic         clk,
   input logic         rst_n,
   input logic         do_push_i,
   input logic         loop_pop_i,
   input logic         sw_wr_i,
   input logic [W-1:0] sw_wr_data_i,
   input logic         sw_rd_i,
   input logic [W-1:0] tos_o,
   input logic         lf_o,
   input logic         nl_o,
   input logic [15:0]  mode_view_o,
   input logic         ovf_irq_o,
   input logic         underflow_o
);
   logic full;
   logic do_sel;
   logic pop_sel;
   assign full    = lf_o & nl_o;
   assign do_sel  = do_push_i & ~sw_wr_i & ~sw_rd_i;
   assign pop_sel = ~sw_wr_i & (sw_rd_i | (~do_push_i & loop_pop_i));

   a_r2_legal_pair: assert property (@(posedge clk) disable iff (!rst_n)
      !(nl_o && !lf_o));

   a_r3_do_push: assert property (@(posedge clk) disable iff (!rst_n)
      (do_sel && !full) |=> (lf_o && nl_o == $past(lf_o) && !ovf_irq_o));

   a_r4_no_overflow_push: assert property (@(posedge clk) disable iff (!rst_n)
      (do_sel && full) |=> (ovf_irq_o && lf_o && nl_o && $stable(tos_o)));

   a_r5_pop_shift: assert property (@(posedge clk) disable iff (!rst_n)
      pop_sel |=> (!nl_o && lf_o == $past(nl_o)));

   a_r6_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_i |=> (lf_o && nl_o == $past(lf_o) && tos_o == $past(sw_wr_data_i)
                   && !ovf_irq_o));

   a_r8_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_sel && !lf_o) |=> (underflow_o && !lf_o && !nl_o && tos_o == '0));

   a_r8_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
      !lf_o |-> tos_o == '0);

   a_r10_view: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_view_o[NL_BIT] == nl_o) && ((mode_view_o & RSVD_MASK) == 16'h0));
endmodule

bind loop_ctx_stack lcs_chk #(
   .W         (W),
   .NL_BIT    (NL_BIT),
   .RSVD_MASK (RSVD_MASK)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .do_push_i    (do_push_i),
   .loop_pop_i   (loop_pop_i),
   .sw_wr_i      (sw_wr_i),
   .sw_wr_data_i (sw_wr_data_i),
   .sw_rd_i      (sw_rd_i),
   .tos_o        (tos_o),
   .lf_o         (lf_o),
   .nl_o         (nl_o),
   .mode_view_o  (mode_view_o),
   .ovf_irq_o    (ovf_irq_o),
   .underflow_o  (underflow_o)
);

// File: tb/sim_loop_ctx_stack.sv
`timescale 1ns/1ps
module sim_loop_ctx_stack;
   typedef struct packed {
      logic [15:0] tos;
      logic        lf;
      logic        nl;
      logic        ovf;
      logic        udf;
      logic [15:0] view;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        do_push_i = 1'b0;
   logic [15:0] do_ctx_i = '0;
   logic        loop_pop_i = 1'b0;
   logic        sw_wr_i = 1'b0;
   logic [15:0] sw_wr_data_i = '0;
   logic        sw_rd_i = 1'b0;
   logic [15:0] mode_ctl_i = '0;
   logic [15:0] tos_o;
   logic        lf_o;
   logic        nl_o;
   logic [15:0] mode_view_o;
   logic        ovf_irq_o;
   logic        underflow_o;

   int checks = 0;
   int errors = 0;

   exp_t  exp_q[$];
   string tag_q[$];

   logic        m_lf = 1'b0;
   logic        m_nl = 1'b0;
   logic [15:0] m_e0 = '0;
   logic [15:0] m_e1 = '0;

   always #5 clk = ~clk;

   loop_ctx_stack u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .do_push_i    (do_push_i),
      .do_ctx_i     (do_ctx_i),
      .loop_pop_i   (loop_pop_i),
      .sw_wr_i      (sw_wr_i),
      .sw_wr_data_i (sw_wr_data_i),
      .sw_rd_i      (sw_rd_i),
      .mode_ctl_i   (mode_ctl_i),
      .tos_o        (tos_o),
      .lf_o         (lf_o),
      .nl_o         (nl_o),
      .mode_view_o  (mode_view_o),
      .ovf_irq_o    (ovf_irq_o),
      .underflow_o  (underflow_o)
   );

   function automatic logic [15:0] view_of(logic [15:0] mc, logic nl);
      return (mc & 16'h017B) | {nl, 15'h0};
   endfunction

   task automatic model_pop(output logic udf);
      udf  = ~m_lf;
      m_e0 = m_e1;
      m_e1 = '0;
      m_lf = m_nl;
      m_nl = 1'b0;
   endtask

   task automatic model_push(input logic [15:0] v);
      m_e1 = m_e0;
      m_e0 = v;
      m_nl = m_lf;
      m_lf = 1'b1;
   endtask

   // Driver: drives one request cycle, updates the model, queues expected state.
   task automatic op(input logic wr, input logic rd, input logic dop,
                     input logic lpop, input logic [15:0] ctx,
                     input logic [15:0] wdat, input logic [15:0] mc,
                     input string tag);
      exp_t e;
      logic ovf;
      logic udf;
      logic [15:0] pre_top;
      ovf = 1'b0;
      udf = 1'b0;
      @(negedge clk);
      #1;
      sw_wr_i      = wr;
      sw_rd_i      = rd;
      do_push_i    = dop;
      loop_pop_i   = lpop;
      do_ctx_i     = ctx;
      sw_wr_data_i = wdat;
      mode_ctl_i   = mc;
      pre_top      = m_lf ? m_e0 : 16'h0;
      if (!wr && rd) begin
         #1;
         checks++;
         if (tos_o !== pre_top) begin
            errors++;
            $display("FAIL R7 %s: same-cycle read tos=%h expected %h", tag, tos_o, pre_top);
         end
      end
      if (wr)                    model_push(wdat);
      else if (rd)               model_pop(udf);
      else if (dop) begin
         if (m_lf && m_nl)       ovf = 1'b1;
         else                    model_push(ctx);
      end else if (lpop)         model_pop(udf);
      @(posedge clk);
      #1;
      sw_wr_i    = 1'b0;
      sw_rd_i    = 1'b0;
      do_push_i  = 1'b0;
      loop_pop_i = 1'b0;
      e.tos  = m_lf ? m_e0 : 16'h0;
      e.lf   = m_lf;
      e.nl   = m_nl;
      e.ovf  = ovf;
      e.udf  = udf;
      e.view = view_of(mc, m_nl);
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // Monitor: compares the design's state against queued expectations.
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         exp_t  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (tos_o !== e.tos || lf_o !== e.lf || nl_o !== e.nl ||
             ovf_irq_o !== e.ovf || underflow_o !== e.udf ||
             mode_view_o !== e.view) begin
            errors++;
            $display("FAIL %s: tos=%h lf=%b nl=%b ovf=%b udf=%b view=%h expected tos=%h lf=%b nl=%b ovf=%b udf=%b view=%h",
                     t, tos_o, lf_o, nl_o, ovf_irq_o, underflow_o, mode_view_o,
                     e.tos, e.lf, e.nl, e.ovf, e.udf, e.view);
         end
         checks++;
         if (nl_o === 1'b1 && lf_o === 1'b0) begin
            errors++;
            $display("FAIL R2 %s: illegal pair nl=%b lf=%b expected not 10", t, nl_o, lf_o);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (lf_o !== 1'b0 || nl_o !== 1'b0 || tos_o !== 16'h0 ||
          ovf_irq_o !== 1'b0 || underflow_o !== 1'b0) begin
         errors++;
         $display("FAIL R1 in reset: lf=%b nl=%b tos=%h ovf=%b udf=%b expected all zero",
                  lf_o, nl_o, tos_o, ovf_irq_o, underflow_o);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (lf_o !== 1'b0 || nl_o !== 1'b0 || tos_o !== 16'h0 ||
          ovf_irq_o !== 1'b0 || underflow_o !== 1'b0) begin
         errors++;
         $display("FAIL R1 after reset: lf=%b nl=%b tos=%h expected zero", lf_o, nl_o, tos_o);
      end

      // Empty-stack pops (R8, R7)
      op(0,0,0,1, 16'h0,    16'h0,    16'h0000, "R8 loop end on empty");
      op(0,1,0,0, 16'h0,    16'h0,    16'h0000, "R8 R7 sw read on empty");
      op(0,0,0,0, 16'h0,    16'h0,    16'h0000, "R8 idle clears underflow");
      // Fill by loop starts, then overflow (R3, R4)
      op(0,0,1,0, 16'hA11A, 16'h0,    16'h0000, "R3 first loop start");
      op(0,0,1,0, 16'hB22B, 16'h0,    16'hFFFF, "R3 R10 second loop start");
      op(0,0,1,0, 16'hC33C, 16'h0,    16'hFFFF, "R4 third loop start overflows");
      op(0,0,0,0, 16'h0,    16'h0,    16'h0000, "R4 overflow pulse ends");
      // Drain by loop ends (R5)
      op(0,0,0,1, 16'h0,    16'h0,    16'hFFFF, "R5 inner loop end");
      op(0,0,0,1, 16'h0,    16'h0,    16'hFFFF, "R5 R10 outer loop end");
      // Software writes, including write into full stack (R6)
      op(1,0,0,0, 16'h0,    16'h1111, 16'h0000, "R6 sw write one");
      op(1,0,0,0, 16'h0,    16'h2222, 16'h0000, "R6 sw write two");
      op(1,0,0,0, 16'h0,    16'h3333, 16'h0000, "R6 sw write full drops bottom");
      // Software reads (R7)
      op(0,1,0,0, 16'h0,    16'h0,    16'h0000, "R7 sw read top");
      op(0,1,0,0, 16'h0,    16'h0,    16'h0000, "R7 sw read last");
      op(0,1,0,0, 16'h0,    16'h0,    16'h0000, "R7 R8 sw read empty");
      // Priority (R9)
      op(1,1,1,1, 16'hDEAD, 16'h5A5A, 16'h0000, "R9 write beats all");
      op(0,1,1,1, 16'hBEEF, 16'h0,    16'h0000, "R9 read beats loop start");
      op(0,0,1,1, 16'h7007, 16'h0,    16'h0000, "R9 loop start beats loop end");
      op(0,0,1,0, 16'h8008, 16'h0,    16'h0000, "R9 second level");
      op(0,0,1,1, 16'h9009, 16'h0,    16'h0000, "R9 R4 full start beats end");
      op(0,0,0,1, 16'h0,    16'h0,    16'hFFFF, "R5 R10 pop to one level");
      op(0,0,0,0, 16'h0,    16'h0,    16'h0000, "R10 view zero mode");
      @(negedge clk);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule